// File: doc/BRIEF.md
# Scan Test Sequencer with Abort-on-Fail

This block runs scan-based manufacturing test over several embedded cores, one core at a time, in an order loaded by the host. Each core has its own wrapper chain length `L` (the longest chain; shorter chains are padded by the pattern source) and its own pattern count `P`. For each core the block first loads a stimulus, then captures. After that it repeats a combined cycle that unloads the previous response while loading the next stimulus, followed by a capture. It ends with a final unload. A core therefore takes exactly `(L+1)*P + L` clock cycles, and a session takes the sum of these over all cores.

An external pattern source supplies stimulus bits, expected response bits and a don't-care mask for every wrapper chain. It follows the `stim_req`, `cmp_en` and `cur_core` outputs. The block forwards the stimulus to the chains and compares each returning response bit. When abort mode is selected, the first unmasked mismatch stops the whole session at once, so no later core is tested. Otherwise every core is run, and a sticky fail flag is kept for each core. A cycle counter reports the length of the session and stops counting when the session ends.

Top module: `scan_abort_seq`

## Requirements
- R1: For a core with chain length L and pattern count P, the sequence is L cycles with scan_en high, then a capture cycle (capture high, scan_en low), then P-1 groups of L shift cycles plus one capture cycle, then L final unload cycles, for (L+1)*P+L cycles in total. L and P are at least 1.
- R2: Test slots run in ascending slot order. Slot k tests the core whose index is held in bits [k*IDX_W +: IDX_W] of cfg_order. That core's L is read from cfg_len[c*LEN_W +: LEN_W] and its P from cfg_pat[c*PAT_W +: PAT_W]. cur_core shows the core under test.
- R3: scan_in equals stim_bits while stim_req is high, which is every shift cycle except the final unload. scan_in is all zeros during capture and during the final unload.
- R4: Responses are compared only while cmp_en is high, which is every shift cycle after the core's first capture. Bit differences on the first load or on a capture cycle are never reported.
- R5: A mask bit of 1 makes the response bit of that chain a don't-care.
- R6: With abort_en high (sampled when start is accepted), an unmasked mismatch in cycle n of the session raises done at the next cycle. The session then lasts n+1 cycles, and no later core is tested.
- R7: With abort_en low, every core is run to completion. fail_flags[c] is set for each core c that had a mismatch and stays set. fail_core holds the first core that failed, and fail goes high.
- R8: busy is high for every session cycle. done rises one cycle after the last unload cycle of the last slot. cyc_cnt then equals the session length and holds that value while done stays high.
- R9: start is ignored while busy. When idle or done, start begins a new session and clears fail, fail_core, fail_flags and cyc_cnt.
- R10: After reset, busy, done, fail, scan_en, capture and cyc_cnt are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | Begin a session |
| abort_en | input | 1 | 1: stop on first failure; 0: run all cores |
| cfg_len | input | NCORE*LEN_W | Chain length per core |
| cfg_pat | input | NCORE*PAT_W | Pattern count per core |
| cfg_order | input | NCORE*IDX_W | Core index per test slot |
| stim_bits | input | NCHAIN | Stimulus bit per wrapper chain |
| exp_bits | input | NCHAIN | Expected response bit per chain |
| mask_bits | input | NCHAIN | 1 marks that chain's response as don't-care |
| resp_bits | input | NCHAIN | Serial response per chain |
| scan_en | output | 1 | Scan shift enable |
| scan_in | output | NCHAIN | Serial stimulus to each chain |
| capture | output | 1 | One-cycle capture pulse |
| stim_req | output | 1 | Source must present a stimulus this cycle |
| cmp_en | output | 1 | Responses are compared this cycle |
| cur_core | output | IDX_W | Core under test |
| busy | output | 1 | Session running |
| done | output | 1 | Session ended |
| fail | output | 1 | At least one mismatch seen |
| fail_core | output | IDX_W | First failing core |
| fail_flags | output | NCORE | Sticky per-core fail flags |
| cyc_cnt | output | CYC_W | Session cycle counter |

## Verification
The inline assertions check the local rules on every cycle: a capture is always followed by a shift, comparison only starts right after a capture, an aborting mismatch is followed by done, fail flags stay set, and the counter does not move once the session has ended. These rules cannot show that the cycle totals are right, that the slot order is followed, or that mismatches on load cycles, capture cycles and masked bits are ignored. The bench scenarios show these by checking every output on every cycle against a model built from the length and pattern formula. They also cover faults injected at chosen session cycles in both abort modes, and a start pulse that arrives in the middle of a session.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOAD   = 3'd1,
    ST_CAPT   = 3'd2,
    ST_SHIFT  = 3'd3,
    ST_UNLOAD = 3'd4,
    ST_DONE   = 3'd5
  } seq_st_e;
endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int LEN_W = 8,
  parameter int PAT_W = 8,
  parameter int CYC_W = 24,
  parameter int IDX_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   abort_en,
  input  logic [NCORE*LEN_W-1:0] cfg_len,
  input  logic [NCORE*PAT_W-1:0] cfg_pat,
  input  logic [NCORE*IDX_W-1:0] cfg_order,
  input  logic                   miss,
  output seq_st_e                st,
  output logic [IDX_W-1:0]       cur_core,
  output logic [CYC_W-1:0]       cyc_cnt,
  output logic                   clr
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NCORE - 1);

  seq_st_e          st_q, st_d;
  logic [LEN_W-1:0] bit_q, bit_d;
  logic [PAT_W-1:0] pat_q, pat_d;
  logic [IDX_W-1:0] slot_q, slot_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             abort_q, abort_d;
  logic             cyc_en;
  logic [LEN_W-1:0] cur_len;
  logic [PAT_W-1:0] cur_pat;
  logic             last_bit, last_pat, last_slot, accept, busy, cmp_st;

  assign cur_core  = cfg_order[slot_q*IDX_W +: IDX_W];
  assign cur_len   = cfg_len[cur_core*LEN_W +: LEN_W];
  assign cur_pat   = cfg_pat[cur_core*PAT_W +: PAT_W];
  assign last_bit  = (bit_q == cur_len - LEN_W'(1));
  assign last_pat  = ((pat_q + PAT_W'(1)) == cur_pat);
  assign last_slot = (slot_q == LAST_SLOT);
  assign busy      = (st_q == ST_LOAD) || (st_q == ST_CAPT) ||
                     (st_q == ST_SHIFT) || (st_q == ST_UNLOAD);
  assign cmp_st    = (st_q == ST_SHIFT) || (st_q == ST_UNLOAD);
  assign accept    = start && ((st_q == ST_IDLE) || (st_q == ST_DONE));

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    pat_d   = pat_q;
    slot_d  = slot_q;
    abort_d = abort_q;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          st_d    = ST_LOAD;
          bit_d   = '0;
          pat_d   = '0;
          slot_d  = '0;
          abort_d = abort_en;
        end
      end
      ST_LOAD, ST_SHIFT: begin
        if (last_bit) begin
          st_d  = ST_CAPT;
          bit_d = '0;
        end else begin
          bit_d = bit_q + LEN_W'(1);
        end
      end
      ST_CAPT: begin
        pat_d = pat_q + PAT_W'(1);
        st_d  = last_pat ? ST_UNLOAD : ST_SHIFT;
      end
      ST_UNLOAD: begin
        if (last_bit) begin
          bit_d = '0;
          pat_d = '0;
          if (last_slot) begin
            st_d = ST_DONE;
          end else begin
            slot_d = slot_q + IDX_W'(1);
            st_d   = ST_LOAD;
          end
        end else begin
          bit_d = bit_q + LEN_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (cmp_st && miss && abort_q) st_d = ST_DONE;
  end

  assign cyc_en = accept || busy;
  assign cyc_d  = accept ? '0 : cyc_q + CYC_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      bit_q   <= '0;
      pat_q   <= '0;
      slot_q  <= '0;
      abort_q <= 1'b0;
      cyc_q   <= '0;
    end else begin
      st_q    <= st_d;
      bit_q   <= bit_d;
      pat_q   <= pat_d;
      slot_q  <= slot_d;
      abort_q <= abort_d;
      if (cyc_en) cyc_q <= cyc_d;
    end
  end

  assign st      = st_q;
  assign cyc_cnt = cyc_q;
  assign clr     = accept;

  // R1: a capture is always followed by a shift phase
  assert_capt_then_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CAPT) |=> ((st_q == ST_SHIFT) || (st_q == ST_UNLOAD)));
  // R6: an aborting mismatch ends the session on the next cycle
  assert_abort_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_st && miss && abort_q) |=> (st_q == ST_DONE));
  // R8: the counter holds once the session has ended
  assert_cyc_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_DONE) && !start) |=> $stable(cyc_q));
  // R9: start while busy does not restart the counter
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (cyc_q != '0));
endmodule

// File: rtl/scan_resp_cmp.sv
module scan_resp_cmp #(
  parameter int NCHAIN = 4
) (
  input  logic              en,
  input  logic [NCHAIN-1:0] resp,
  input  logic [NCHAIN-1:0] expv,
  input  logic [NCHAIN-1:0] mask,
  output logic              miss
);
  logic [NCHAIN-1:0] diff;

  for (genvar i = 0; i < NCHAIN; i++) begin : g_bit
    assign diff[i] = en && !mask[i] && (resp[i] != expv[i]);
  end

  assign miss = |diff;
endmodule

// File: rtl/scan_fail_log.sv
module scan_fail_log #(
  parameter int NCORE = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit,
  input  logic [IDX_W-1:0] core,
  output logic [NCORE-1:0] flags,
  output logic             any_fail,
  output logic [IDX_W-1:0] first_core
);
  logic [NCORE-1:0] flags_q, flags_d;
  logic             any_q, any_d;
  logic [IDX_W-1:0] first_q, first_d;
  logic             upd;

  always_comb begin
    flags_d = flags_q;
    any_d   = any_q;
    first_d = first_q;
    if (clr) begin
      flags_d = '0;
      any_d   = 1'b0;
      first_d = '0;
    end else if (hit) begin
      for (int i = 0; i < NCORE; i++) begin
        if (core == IDX_W'(i)) flags_d[i] = 1'b1;
      end
      any_d = 1'b1;
      if (!any_q) first_d = core;
    end
  end

  assign upd = clr || hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      any_q   <= 1'b0;
      first_q <= '0;
    end else if (upd) begin
      flags_q <= flags_d;
      any_q   <= any_d;
      first_q <= first_d;
    end
  end

  assign flags      = flags_q;
  assign any_fail   = any_q;
  assign first_core = first_q;

  // R7: per-core fail flags are sticky until a new session clears them
  assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/scan_abort_seq.sv
module scan_abort_seq
  import scan_seq_pkg::*;
#(
  parameter int NCORE  = 4,
  parameter int NCHAIN = 4,
  parameter int LEN_W  = 8,
  parameter int PAT_W  = 8,
  parameter int CYC_W  = 24,
  localparam int IDX_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    abort_en,
  input  logic [NCORE*LEN_W-1:0]  cfg_len,
  input  logic [NCORE*PAT_W-1:0]  cfg_pat,
  input  logic [NCORE*IDX_W-1:0]  cfg_order,
  input  logic [NCHAIN-1:0]       stim_bits,
  input  logic [NCHAIN-1:0]       exp_bits,
  input  logic [NCHAIN-1:0]       mask_bits,
  input  logic [NCHAIN-1:0]       resp_bits,
  output logic                    scan_en,
  output logic [NCHAIN-1:0]       scan_in,
  output logic                    capture,
  output logic                    stim_req,
  output logic                    cmp_en,
  output logic [IDX_W-1:0]        cur_core,
  output logic                    busy,
  output logic                    done,
  output logic                    fail,
  output logic [IDX_W-1:0]        fail_core,
  output logic [NCORE-1:0]        fail_flags,
  output logic [CYC_W-1:0]        cyc_cnt
);
  seq_st_e st;
  logic    miss, clr;

  scan_seq_ctrl #(
    .NCORE(NCORE), .LEN_W(LEN_W), .PAT_W(PAT_W), .CYC_W(CYC_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .abort_en(abort_en),
    .cfg_len(cfg_len), .cfg_pat(cfg_pat), .cfg_order(cfg_order),
    .miss(miss), .st(st), .cur_core(cur_core), .cyc_cnt(cyc_cnt), .clr(clr)
  );

  assign scan_en  = (st == ST_LOAD) || (st == ST_SHIFT) || (st == ST_UNLOAD);
  assign capture  = (st == ST_CAPT);
  assign stim_req = (st == ST_LOAD) || (st == ST_SHIFT);
  assign cmp_en   = (st == ST_SHIFT) || (st == ST_UNLOAD);
  assign busy     = scan_en || capture;
  assign done     = (st == ST_DONE);
  assign scan_in  = stim_req ? stim_bits : '0;

  scan_resp_cmp #(.NCHAIN(NCHAIN)) u_cmp (
    .en(cmp_en), .resp(resp_bits), .expv(exp_bits), .mask(mask_bits), .miss(miss)
  );

  scan_fail_log #(.NCORE(NCORE), .IDX_W(IDX_W)) u_log (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hit(miss), .core(cur_core),
    .flags(fail_flags), .any_fail(fail), .first_core(fail_core)
  );

  // R4: comparison only begins right after a capture
  assert_cmp_after_capt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_en) |-> $past(capture));
endmodule

// File: tb/sim_scan_abort_seq.sv
module sim_scan_abort_seq;
  localparam int NC = 3;
  localparam int NCH = 2;
  localparam int LW = 6;
  localparam int PW = 6;
  localparam int CW = 16;
  localparam int IW = 2;

  typedef struct packed {
    logic [5:0] l0, l1, l2, p0, p1, p2;
    logic [1:0] o0, o1, o2;
    logic       ab;
    logic [7:0] f;
    logic       msk;
    logic       mid;
  } vec_t;

  // per-core L/P, slot order, abort, fault cycle (255 none), masked, mid-run start
  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{6'd3,6'd2,6'd4, 6'd2,6'd1,6'd3, 2'd0,2'd1,2'd2, 1'b1, 8'd255, 1'b0, 1'b0},
    '{6'd3,6'd2,6'd4, 6'd2,6'd1,6'd3, 2'd2,2'd0,2'd1, 1'b1, 8'd25,  1'b0, 1'b0},
    '{6'd3,6'd2,6'd4, 6'd2,6'd1,6'd3, 2'd2,2'd0,2'd1, 1'b0, 8'd25,  1'b0, 1'b0},
    '{6'd3,6'd2,6'd4, 6'd2,6'd1,6'd3, 2'd2,2'd0,2'd1, 1'b1, 8'd19,  1'b0, 1'b0},
    '{6'd3,6'd2,6'd4, 6'd2,6'd1,6'd3, 2'd2,2'd0,2'd1, 1'b1, 8'd25,  1'b1, 1'b0},
    '{6'd3,6'd2,6'd4, 6'd2,6'd1,6'd3, 2'd2,2'd0,2'd1, 1'b1, 8'd22,  1'b0, 1'b0},
    '{6'd1,6'd1,6'd1, 6'd1,6'd1,6'd1, 2'd1,2'd2,2'd0, 1'b1, 8'd255, 1'b0, 1'b1},
    '{6'd3,6'd2,6'd4, 6'd2,6'd1,6'd3, 2'd0,2'd1,2'd2, 1'b1, 8'd34,  1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic abort_en = 1'b0;
  logic [NC*LW-1:0] cfg_len = '0;
  logic [NC*PW-1:0] cfg_pat = '0;
  logic [NC*IW-1:0] cfg_order = '0;
  logic [NCH-1:0] stim_bits = '0, exp_bits = '0, mask_bits = '0, resp_bits = '0;
  logic scan_en, capture, stim_req, cmp_en, busy, done, fail;
  logic [NCH-1:0] scan_in;
  logic [IW-1:0] cur_core, fail_core;
  logic [NC-1:0] fail_flags;
  logic [CW-1:0] cyc_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  scan_abort_seq #(.NCORE(NC), .NCHAIN(NCH), .LEN_W(LW), .PAT_W(PW), .CYC_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .abort_en(abort_en),
    .cfg_len(cfg_len), .cfg_pat(cfg_pat), .cfg_order(cfg_order),
    .stim_bits(stim_bits), .exp_bits(exp_bits), .mask_bits(mask_bits),
    .resp_bits(resp_bits), .scan_en(scan_en), .scan_in(scan_in),
    .capture(capture), .stim_req(stim_req), .cmp_en(cmp_en),
    .cur_core(cur_core), .busy(busy), .done(done), .fail(fail),
    .fail_core(fail_core), .fail_flags(fail_flags), .cyc_cnt(cyc_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int len_of(vec_t v, int c);
    return (c == 0) ? int'(v.l0) : (c == 1) ? int'(v.l1) : int'(v.l2);
  endfunction
  function automatic int pat_of(vec_t v, int c);
    return (c == 0) ? int'(v.p0) : (c == 1) ? int'(v.p1) : int'(v.p2);
  endfunction
  function automatic int ord_of(vec_t v, int s);
    return (s == 0) ? int'(v.o0) : (s == 1) ? int'(v.o1) : int'(v.o2);
  endfunction
  function automatic int ctime(vec_t v, int s);
    int c = ord_of(v, s);
    return (len_of(v, c) + 1) * pat_of(v, c) + len_of(v, c);
  endfunction

  task automatic locate(input vec_t v, input int t, output int s, output int c);
    int off = 0;
    s = -1; c = 0;
    for (int k = 0; k < NC; k++) begin
      if (s < 0 && t < off + ctime(v, k)) begin s = k; c = t - off; end
      off += ctime(v, k);
    end
  endtask

  task automatic run(input vec_t v, input int idx);
    int total = 0, ex_total, fs, fc, L, P, tcyc, s, c, core;
    int e1 = 0, e2 = 0, e3 = 0, e4 = 0, e8 = 0;
    bit real_fail = 0, ecap, estim, ecmp;
    int ecore = 0;
    for (int k = 0; k < NC; k++) total += ctime(v, k);
    if (v.f != 8'd255) begin
      locate(v, int'(v.f), fs, fc);
      L = len_of(v, ord_of(v, fs));
      real_fail = (fc >= L + 1) && (((fc - (L + 1)) % (L + 1)) != L) && !v.msk;
      ecore = ord_of(v, fs);
    end
    ex_total = (real_fail && v.ab) ? int'(v.f) + 1 : total;
    cfg_len   = {v.l2, v.l1, v.l0};
    cfg_pat   = {v.p2, v.p1, v.p0};
    cfg_order = {v.o2, v.o1, v.o0};
    abort_en  = v.ab;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    tcyc = 0;
    while (!done && tcyc < 400) begin
      stim_bits = 2'(tcyc) ^ 2'b01;
      exp_bits  = 2'(tcyc >> 1);
      resp_bits = exp_bits ^ ((tcyc == int'(v.f)) ? 2'b10 : 2'b00);
      mask_bits = (tcyc == int'(v.f) && v.msk) ? 2'b10 : 2'b00;
      start     = v.mid && (tcyc == 4);
      #1;
      if (tcyc < ex_total) begin
        locate(v, tcyc, s, c);
        core = ord_of(v, s);
        L = len_of(v, core);
        P = pat_of(v, core);
        ecap  = (c >= L) && (((c - L) % (L + 1)) == 0) && (c < (L + 1) * P);
        estim = !ecap && (c < (L + 1) * P);
        ecmp  = !ecap && (c > L);
        if (capture != ecap || scan_en != !ecap) e1++;
        if (int'(cur_core) != core) e2++;
        if (scan_in != (estim ? stim_bits : 2'b00) || stim_req != estim) e3++;
        if (cmp_en != ecmp) e4++;
        if (!busy) e8++;
      end
      @(negedge clk);
      start = 1'b0;
      tcyc++;
    end
    chk(e1 == 0, $sformatf("R1 shift/capture pattern vec %0d", idx), e1, 0);
    chk(e2 == 0, $sformatf("R2 slot order vec %0d", idx), e2, 0);
    chk(e3 == 0, $sformatf("R3 scan_in forwarding vec %0d", idx), e3, 0);
    chk(e4 == 0, $sformatf("R4 compare window vec %0d", idx), e4, 0);
    chk(e8 == 0, $sformatf("R8 busy during session vec %0d", idx), e8, 0);
    chk(tcyc == ex_total, $sformatf("R8 done timing vec %0d (R6 when aborted)", idx), tcyc, ex_total);
    chk(int'(cyc_cnt) == ex_total, $sformatf("R8 cycle count vec %0d", idx), int'(cyc_cnt), ex_total);
    chk(fail == real_fail, $sformatf("R5/R7 fail flag vec %0d", idx), int'(fail), int'(real_fail));
    chk(fail_flags == (real_fail ? (3'b001 << ecore) : 3'b000),
        $sformatf("R7 per-core flags vec %0d", idx), int'(fail_flags),
        real_fail ? (1 << ecore) : 0);
    if (real_fail)
      chk(int'(fail_core) == ecore, $sformatf("R7 fail_core vec %0d", idx), int'(fail_core), ecore);
    repeat (2) @(negedge clk);
    chk(done && int'(cyc_cnt) == ex_total, $sformatf("R8 counter frozen vec %0d", idx),
        int'(cyc_cnt), ex_total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy && !done && !fail && !scan_en && !capture && cyc_cnt == '0,
        "R10 reset state", int'({busy, done, fail, scan_en, capture}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && cyc_cnt == '0, "R10 idle after reset", int'({busy, done}), 0);
    // table walk: vec 3 follows a failing run and must report pass (R9 clear)
    for (int i = 0; i < NV; i++) run(TBL[i], i);
    // R9: restart from done after a failing abort run clears status
    run(TBL[1], 100);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!fail && fail_flags == '0 && busy, "R9 restart clears status",
        int'({fail, fail_flags}), 0);
    while (!done) @(negedge clk);
    report();
  end
endmodule